// File: doc/BRIEF.md
# Multi-line serial receive silo

This block is the shared receive queue of an eight-line serial multiplexer controller. Each line receiver presents a character with a request bit. Each cycle the block accepts at most one of them and tags it with its line number. It packs the result into a 16-bit word and stores it in a 64-slot circular buffer. Because one slot is kept free to tell full from empty, 63 words can be queued.

Software drains the queue through a read strobe. Each qualified read pops one word, which appears on the read-data port on the next cycle. The block also keeps three status bits:
- a master scan enable, written through a small control-write port;
- a receive-done flag, meaning data is waiting;
- a silo-alarm flag, raised once more than a set number of characters have arrived since the last read.

A clear command empties the queue and zeroes the control state.

Top module: `mux_rx_silo`

## Requirements
- R1: After reset, `rd_data`, `rx_done`, `silo_alarm`, `scan_en` and `line_taken` are all zero and the queue is empty.
- R2: A queued word has bit 15 = 1, bits 14:11 = 0, bits 10:8 = the source line number and bits 7:0 = the character.
- R3: When one or more lines request in a cycle, only the lowest-numbered requesting line is accepted. `line_taken` is one-hot for that line in the same cycle, and the other lines are not taken. No line is taken while a clear is being written.
- R4: The queue holds at most 63 words. While 63 are queued, `line_taken` stays zero.
- R5: With `scan_en` = 1, each `rd_strobe` pops the oldest word. The popped word appears on `rd_data` one cycle after the strobe, in arrival order.
- R6: Accepting a character sets `rx_done`. A read with `scan_en` = 1 clears `rx_done`, unless words remain after the pop or a character is accepted in the same cycle.
- R7: `silo_alarm` sets when the number of characters accepted since the last read with `scan_en` = 1 exceeds `ALARM_LEVEL` (16). That read clears the flag and restarts the count.
- R8: A read with `scan_en` = 0 loads 0 into `rd_data`, pops nothing and leaves `rx_done` and `silo_alarm` unchanged.
- R9: A read with `scan_en` = 1 and an empty queue loads 0 into `rd_data`, so its bit 15 is 0.
- R10: A control write with `ctl_clear` = 1 empties the queue and zeroes `scan_en`, `rx_done`, `silo_alarm` and the alarm count on the next edge.
- R11: A control write with `ctl_clear` = 0 loads `scan_en` from `ctl_scan_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_valid | input | NUM_LINES | Per-line character request |
| line_char | input | NUM_LINES*8 | Per-line character, line i in bits 8i+7:8i |
| line_taken | output | NUM_LINES | One-hot: the line accepted this cycle |
| ctl_wr | input | 1 | Control write strobe |
| ctl_clear | input | 1 | Control write data: clear command |
| ctl_scan_en | input | 1 | Control write data: master scan enable |
| rd_strobe | input | 1 | Receive-buffer read strobe |
| rd_data | output | 16 | Word returned by the last read |
| scan_en | output | 1 | Master scan enable |
| rx_done | output | 1 | Receive-done status |
| silo_alarm | output | 1 | Silo-alarm status |

## Verification
A corrupted pointer or level counter shows at the ports in one of three ways. Read data may come out of order or out of step with what was pushed. `line_taken` may rise while 63 words are held. Or `rx_done` may disagree with whether any word is left. All of these show within one cycle of the next push or read. A wrong alarm count shows as `silo_alarm` rising one push too early or too late. The reference model compares every output on every clock, so each such error is caught on the first cycle it reaches a port.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int CHAR_W  = 8;
  localparam int LINE_FW = 3;
  localparam int WORD_W  = 16;

  function automatic logic [WORD_W-1:0] make_word(input logic [LINE_FW-1:0] ln,
                                                  input logic [CHAR_W-1:0] ch);
    logic [WORD_W-1:0] w;
    w = '0;
    w[15] = 1'b1;
    w[10:8] = ln;
    w[7:0] = ch;
    return w;
  endfunction
endpackage

// File: rtl/rxs_arb.sv
module rxs_arb #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic          enable,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N:0] below;
  assign below[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_pri
      assign below[g+1] = below[g] | req[g];
      assign gnt[g]     = enable & req[g] & ~below[g];
    end
  endgenerate

  assign any = |gnt;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (gnt[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
  parameter int ADDR_W = 6,
  parameter int W      = 16,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int LVL_W = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);
  logic [W-1:0]      mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n;
  logic [ADDR_W-1:0] used;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = ((wr_ptr + ADDR_W'(1)) == rd_ptr);
  assign used  = wr_ptr - rd_ptr;
  assign level = {1'b0, used};
  assign head  = mem[rd_ptr];

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    if (clr) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
    end else begin
      if (push && !full) wr_ptr_n = wr_ptr + ADDR_W'(1);
      if (pop && !empty) rd_ptr_n = rd_ptr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !clr) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/rxs_status.sv
module rxs_status #(
  parameter int CNT_W       = 7,
  parameter int ALARM_LEVEL = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ctl_wr,
  input  logic ctl_scan_en,
  input  logic rd_req,
  input  logic push,
  input  logic remain,
  output logic scan_en,
  output logic rx_done,
  output logic silo_alarm
);
  logic [CNT_W-1:0] cnt, cnt_n;
  logic scan_en_n, rx_done_n, alarm_n;

  always_comb begin
    cnt_n     = cnt;
    scan_en_n = scan_en;
    rx_done_n = rx_done;
    alarm_n   = silo_alarm;
    if (clr) begin
      cnt_n     = '0;
      scan_en_n = 1'b0;
      rx_done_n = 1'b0;
      alarm_n   = 1'b0;
    end else begin
      if (ctl_wr) scan_en_n = ctl_scan_en;
      if (rd_req) begin
        cnt_n     = {{(CNT_W-1){1'b0}}, push};
        rx_done_n = remain;
        alarm_n   = 1'b0;
      end else if (push) begin
        if (cnt != {CNT_W{1'b1}}) cnt_n = cnt + CNT_W'(1);
        rx_done_n = 1'b1;
      end
      if (push && (cnt_n > CNT_W'(ALARM_LEVEL))) alarm_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      scan_en    <= 1'b0;
      rx_done    <= 1'b0;
      silo_alarm <= 1'b0;
    end else begin
      cnt        <= cnt_n;
      scan_en    <= scan_en_n;
      rx_done    <= rx_done_n;
      silo_alarm <= alarm_n;
    end
  end
endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo #(
  parameter int NUM_LINES   = 8,
  parameter int ADDR_W      = 6,
  parameter int ALARM_LEVEL = 16,
  localparam int LINE_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int LVL_W      = ADDR_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LINES-1:0]   line_valid,
  input  logic [NUM_LINES*8-1:0] line_char,
  output logic [NUM_LINES-1:0]   line_taken,
  input  logic                   ctl_wr,
  input  logic                   ctl_clear,
  input  logic                   ctl_scan_en,
  input  logic                   rd_strobe,
  output logic [15:0]            rd_data,
  output logic                   scan_en,
  output logic                   rx_done,
  output logic                   silo_alarm
);
  import rxs_pkg::*;

  logic              clr, push, pop, rd_req, remain, empty, full;
  logic [LINE_W-1:0] idx;
  logic [WORD_W-1:0] wdata, head, rd_data_n;
  logic [LVL_W-1:0]  level, level_after;

  assign clr    = ctl_wr & ctl_clear;
  assign rd_req = rd_strobe & scan_en & ~clr;
  assign pop    = rd_req & ~empty;

  rxs_arb #(.N(NUM_LINES)) u_arb (
    .req(line_valid), .enable(~full & ~clr),
    .gnt(line_taken), .idx(idx), .any(push)
  );

  assign wdata = make_word(LINE_FW'(idx), line_char[idx*CHAR_W +: CHAR_W]);

  rxs_fifo #(.ADDR_W(ADDR_W), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .wdata(wdata),
    .pop(pop), .head(head), .empty(empty), .full(full), .level(level)
  );

  assign level_after = level + LVL_W'(push) - LVL_W'(pop);
  assign remain      = (level_after != '0);

  rxs_status #(.CNT_W(LVL_W), .ALARM_LEVEL(ALARM_LEVEL)) u_status (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ctl_wr(ctl_wr),
    .ctl_scan_en(ctl_scan_en), .rd_req(rd_req), .push(push),
    .remain(remain), .scan_en(scan_en), .rx_done(rx_done),
    .silo_alarm(silo_alarm)
  );

  always_comb begin
    rd_data_n = '0;
    if (scan_en && !empty) rd_data_n = head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_strobe) rd_data <= rd_data_n;
  end
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 6,
  localparam int LVL_W    = ADDR_W + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] line_valid,
  input logic [NUM_LINES-1:0] line_taken,
  input logic                 ctl_wr,
  input logic                 ctl_clear,
  input logic                 rd_strobe,
  input logic [15:0]          rd_data,
  input logic                 scan_en,
  input logic                 rx_done,
  input logic                 silo_alarm,
  input logic [LVL_W-1:0]     level
);
  assert_taken_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_taken));
  assert_taken_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_taken & ~line_valid) == '0);
  assert_no_push_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_W'((1 << ADDR_W) - 1)) |-> (line_taken == '0));
  assert_word_layout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[14:11] == 4'b0) && ((rd_data != 16'h0) == rd_data[15]));
  assert_done_on_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_taken != '0) && !(ctl_wr && ctl_clear)) |=> rx_done);
  assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !scan_en && !ctl_wr && (line_taken == '0))
      |=> (rd_data == 16'h0) && $stable(rx_done) && $stable(silo_alarm));
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_clear) |=> (!rx_done && !silo_alarm && !scan_en));
endmodule

bind mux_rx_silo rxs_checker #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_taken(line_taken),
  .ctl_wr(ctl_wr), .ctl_clear(ctl_clear), .rd_strobe(rd_strobe),
  .rd_data(rd_data), .scan_en(scan_en), .rx_done(rx_done),
  .silo_alarm(silo_alarm), .level(level)
);

// File: tb/test_mux_rx_silo.sv
module test_mux_rx_silo;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] line_valid;
  logic [NL*8-1:0] line_char;
  logic [NL-1:0] line_taken;
  logic ctl_wr, ctl_clear, ctl_scan_en, rd_strobe;
  logic [15:0] rd_data;
  logic scan_en, rx_done, silo_alarm;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model state
  logic [15:0] q[$];
  bit m_mse, m_done, m_alarm;
  int m_cnt;
  logic [15:0] m_rd;

  always #4 clk = ~clk;

  mux_rx_silo i_mux_rx_silo (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_char(line_char),
    .line_taken(line_taken), .ctl_wr(ctl_wr), .ctl_clear(ctl_clear),
    .ctl_scan_en(ctl_scan_en), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .scan_en(scan_en), .rx_done(rx_done), .silo_alarm(silo_alarm)
  );

  function automatic logic [NL-1:0] exp_taken();
    logic [NL-1:0] t;
    t = '0;
    if (!(ctl_wr && ctl_clear) && q.size() < 63) begin
      for (int i = NL - 1; i >= 0; i--)
        if (line_valid[i]) t = NL'(1) << i;
    end
    return t;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit rd_ok, psh;
      int ln;
      logic [15:0] w;
      psh = 0; ln = 0;
      if (rd_strobe) m_rd = (m_mse && q.size() > 0) ? q[0] : 16'h0;
      if (ctl_wr && ctl_clear) begin
        q.delete();
        m_mse = 0; m_done = 0; m_alarm = 0; m_cnt = 0;
      end else begin
        rd_ok = rd_strobe && m_mse;
        if (q.size() < 63) begin
          for (int i = NL - 1; i >= 0; i--)
            if (line_valid[i]) begin psh = 1; ln = i; end
        end
        w = 16'h8000 | (16'(ln) << 8) | 16'(line_char[ln*8 +: 8]);
        if (rd_ok && q.size() > 0) void'(q.pop_front());
        if (psh) q.push_back(w);
        if (rd_ok) begin
          m_cnt = psh ? 1 : 0;
          m_done = (q.size() > 0);
          m_alarm = 0;
        end else if (psh) begin
          if (m_cnt < 127) m_cnt++;
          m_done = 1;
        end
        if (psh && m_cnt > 16) m_alarm = 1;
        if (ctl_wr) m_mse = ctl_scan_en;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_regs();
    chk("R5 rd_data", 32'(rd_data), 32'(m_rd));
    chk("R6 rx_done", 32'(rx_done), 32'(m_done));
    chk("R7 silo_alarm", 32'(silo_alarm), 32'(m_alarm));
    chk("R11 scan_en", 32'(scan_en), 32'(m_mse));
  endtask

  // inputs already set at a negedge; check comb output, then advance one cycle
  task automatic step();
    #1;
    chk("R3 line_taken", 32'(line_taken), 32'(exp_taken()));
    @(negedge clk);
    cmp_regs();
  endtask

  task automatic idle();
    line_valid = '0; ctl_wr = 0; ctl_clear = 0; ctl_scan_en = 0; rd_strobe = 0;
  endtask

  task automatic put(input int ln, input logic [7:0] ch);
    idle();
    line_valid = NL'(1) << ln;
    line_char[ln*8 +: 8] = ch;
    step();
  endtask

  task automatic rd();
    idle(); rd_strobe = 1; step();
  endtask

  task automatic set_mse(input bit v);
    idle(); ctl_wr = 1; ctl_scan_en = v; step();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_mse = 0; m_done = 0; m_alarm = 0; m_cnt = 0; m_rd = 0;
    rst_n = 0; line_char = '0;
    idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rd_data", 32'(rd_data), 0);
    chk("R1 status", {29'b0, scan_en, rx_done, silo_alarm}, 0);
    chk("R1 line_taken", 32'(line_taken), 0);
    rst_n = 1;
    @(negedge clk);

    set_mse(1);
    // R2: word layout
    put(5, 8'hA7);
    chk("R6 done after push", 32'(rx_done), 1);
    rd();
    chk("R2 word layout", 32'(rd_data), 32'h85A7);
    chk("R6 done cleared", 32'(rx_done), 0);
    // R9: empty read
    rd();
    chk("R9 empty read", 32'(rd_data), 0);

    // R3: several lines at once
    idle();
    line_valid = 8'b1010_0100;
    line_char = 64'h1122_3344_5566_7788;
    #1 chk("R3 lowest line wins", 32'(line_taken), 32'h04);
    @(negedge clk); cmp_regs();
    idle(); line_valid = 8'b1010_0000; step();
    idle(); line_valid = 8'b1000_0000; step();
    rd(); chk("R5 first", 32'(rd_data), 32'h8266);
    rd(); chk("R5 second", 32'(rd_data), 32'h8533);
    rd(); chk("R5 third", 32'(rd_data), 32'h8711);

    // R7 / R4: fill
    for (int k = 0; k < 70; k++) begin
      put(k % 8, 8'(k));
      if (k == 15) chk("R7 alarm not yet at 16", 32'(silo_alarm), 0);
      if (k == 16) chk("R7 alarm at 17", 32'(silo_alarm), 1);
    end
    idle(); line_valid = 8'hFF;
    #1 chk("R4 none taken when full", 32'(line_taken), 0);
    @(negedge clk); cmp_regs();

    // R8: reads ignored with scan disabled
    set_mse(0);
    rd();
    chk("R8 rd_data zero", 32'(rd_data), 0);
    chk("R8 done kept", 32'(rx_done), 1);
    chk("R8 alarm kept", 32'(silo_alarm), 1);
    set_mse(1);
    rd();
    chk("R8 no pop happened", 32'(rd_data), 32'h8000);
    chk("R7 alarm cleared by read", 32'(silo_alarm), 0);
    for (int k = 0; k < 62; k++) rd();
    chk("R6 done after drain", 32'(rx_done), 0);

    // R10: clear
    put(2, 8'h5A); put(3, 8'h5B);
    idle(); ctl_wr = 1; ctl_clear = 1; ctl_scan_en = 1; line_valid = 8'h01;
    #1 chk("R10 no take on clear", 32'(line_taken), 0);
    @(negedge clk); cmp_regs();
    chk("R10 cleared", {29'b0, scan_en, rx_done, silo_alarm}, 0);
    set_mse(1);
    rd(); chk("R10 queue empty", 32'(rd_data), 0);

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      idle();
      for (int l = 0; l < NL; l++) begin
        line_valid[l] = ($urandom % 6) == 0;
        line_char[l*8 +: 8] = 8'($urandom);
      end
      rd_strobe = ($urandom % 3) == 0;
      if (($urandom % 150) == 0) begin
        ctl_wr = 1;
        ctl_scan_en = ($urandom % 4) != 0;
        ctl_clear = ($urandom % 4) == 0;
      end
      step();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule